// File: doc/BRIEF.md
# Banked Multi-Channel DMA Control Register Block

This block is the software-visible control register file of a multi-channel DMA engine. Software reaches it through a simple word-wide read/write port. It holds a handful of global registers: engine reset, descriptor polling control, a per-channel global interrupt mask, and a channel selector and a port selector. It also holds one bank of control state for every channel and one port control word for every port. The per-channel registers are channel control, descriptor base, descriptor count, interrupt enable and interrupt status. Software writes the channel selector first. The banked register offsets then read and write the bank of the selected channel. Port control works the same way through the port selector.

The data movement is not part of this block. Each channel has an event input that marks a completed descriptor. The block records that event in the channel's interrupt status. It combines the status with the channel's enable and the global mask to form a per-channel interrupt line and one combined line. A channel reset bit starts a fixed-length reset sequence. That bit clears itself when the sequence ends, so software can poll it. The engine reset bit clears all channel state in one cycle.

Top module: `dma_regbank`

## Requirements
- R1: After reset every register reads 0, and `ch_on`, `ch_irq` and `irq` are 0.
- R2: The channel select register (offset 0x18, bits 7:0) picks the bank that offsets 0x1C, 0x20, 0x24, 0x28 and 0x2C address. Channel control (0x1C) keeps bit 0 (channel on, driven on `ch_on[ch]`), bit 1 (channel reset), bit 8 (transmit direction) and bits 17:16 (weight). The other bits of channel control read 0. Descriptor base (0x20) keeps all 32 bits. Descriptor count (0x24) keeps bits 15:0. Interrupt enable (0x2C) keeps bits 7:0.
- R3: While the channel select holds a value of NUM_CH or more, the banked offsets read 0 and writes to them change no channel.
- R4: Writing channel control with bit 1 set starts a reset. Bit 1 reads 1 for exactly RST_CYCLES read cycles and then reads 0. At that point the channel's on bit and interrupt status are 0, and its direction and weight are unchanged.
- R5: Interrupt status (0x28) bit 3 is the descriptor-complete flag. A 1 on `ch_event[ch]` sets it for that channel, whichever channel is selected. Writing 1 to bit 3 clears it, so an acknowledge value of 0x7E clears it. Writing 0 to bit 3 leaves it unchanged. When an event and a clear land in the same cycle, the bit stays set.
- R6: `ch_irq[ch]` is 1 exactly when that channel's status bit 3, its interrupt enable bit 3, and bit `ch` of the global interrupt mask (0xF4, bits NUM_CH-1:0) are all 1. `irq` is the OR of all `ch_irq` bits.
- R7: The port select register (0x40, bits 7:0) picks the port that port control (0x44) addresses. Port control keeps bits 11:2 for each port, covering packet drop on bit 6 and endianness swap on bits 11:8. A port select of NUM_PORT or more reads 0 from port control and ignores writes to it.
- R8: Polling control (0x14) keeps bit 31 (polling enable) and bit 6 (divide-by-4 polling clock). Its other bits read 0.
- R9: Writing 1 to bit 0 of global control (0x10) clears the state of every channel and the global interrupt mask in that cycle. Global control always reads 0.
- R10: An address that is not in the register map reads 0, and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe; a write is taken at the rising clock edge |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational from register state |
| ch_event | input | NUM_CH | Per-channel descriptor-complete event pulses |
| ch_on | output | NUM_CH | Channel-on bit of each channel |
| ch_irq | output | NUM_CH | Per-channel interrupt lines |
| irq | output | 1 | OR of all channel interrupt lines |

## Verification
The hardest case to reach from the ports is the one where an event and an acknowledge hit the same status bit in the same cycle. The interrupt mask, the enable and the channel selector must all be in a known state at that moment. Directed steps set up that collision once, on a channel that has a pending flag. A seeded random phase then sends sparse events on every channel. Mixed in with those events are random writes to the selector (including out-of-range values), acknowledges, enables and global masks. A bench model predicts every interrupt line and the status readback after each cycle. The reset sequence is checked by polling the reset bit each cycle and counting the cycles for which it reads 1.

// File: rtl/dma_regbank_pkg.sv
package dma_regbank_pkg;
    // register offsets (byte addresses)
    localparam int unsigned OFF_GCTRL = 32'h010;
    localparam int unsigned OFF_POLL  = 32'h014;
    localparam int unsigned OFF_CSEL  = 32'h018;
    localparam int unsigned OFF_CCTRL = 32'h01C;
    localparam int unsigned OFF_DBASE = 32'h020;
    localparam int unsigned OFF_DCNT  = 32'h024;
    localparam int unsigned OFF_CSTAT = 32'h028;
    localparam int unsigned OFF_CIEN  = 32'h02C;
    localparam int unsigned OFF_PSEL  = 32'h040;
    localparam int unsigned OFF_PCTRL = 32'h044;
    localparam int unsigned OFF_GMASK = 32'h0F4;

    // field positions
    localparam int unsigned B_ON       = 0;
    localparam int unsigned B_CRST     = 1;
    localparam int unsigned B_TX       = 8;
    localparam int unsigned WGT_LO     = 16;
    localparam int unsigned WGT_W      = 2;
    localparam int unsigned B_DONE     = 3;
    localparam int unsigned B_GRST     = 0;
    localparam int unsigned B_POLL_EN  = 31;
    localparam int unsigned B_POLL_DIV = 6;
    localparam int unsigned PC_LO      = 2;
    localparam int unsigned PC_HI      = 11;
    localparam int unsigned PC_W       = PC_HI - PC_LO + 1;
endpackage

// File: rtl/dma_chan_slot.sv
module dma_chan_slot
    import dma_regbank_pkg::*;
#(
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned DCNT_W     = 16,
    parameter int unsigned IE_W       = 8,
    parameter int unsigned RST_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              glob_clr_i,
    input  logic              we_ctrl_i,
    input  logic              we_base_i,
    input  logic              we_dcnt_i,
    input  logic              we_ie_i,
    input  logic              we_is_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              event_i,
    input  logic              gie_i,
    output logic [DATA_W-1:0] ctrl_o,
    output logic [DATA_W-1:0] base_o,
    output logic [DATA_W-1:0] dcnt_o,
    output logic [DATA_W-1:0] ie_o,
    output logic [DATA_W-1:0] is_o,
    output logic              on_o,
    output logic              resetting_o,
    output logic              done_o,
    output logic              irq_o
);
    localparam int unsigned CNT_W = $clog2(RST_CYCLES + 1);

    typedef struct packed {
        logic              on;
        logic              crst;
        logic              tx;
        logic [WGT_W-1:0]  wgt;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] base;
        logic [DCNT_W-1:0] dcnt;
        logic [IE_W-1:0]   ie;
        logic              done;
    } slot_t;

    slot_t q, d;
    wire unused_wdata = ^wdata_i;

    always_comb begin
        d = q;
        if (we_ctrl_i) begin
            d.on  = wdata_i[B_ON];
            d.tx  = wdata_i[B_TX];
            d.wgt = wdata_i[WGT_LO +: WGT_W];
            if (wdata_i[B_CRST] && !q.crst) begin
                d.crst = 1'b1;
                d.cnt  = CNT_W'(RST_CYCLES);
            end
        end
        if (we_base_i) d.base = wdata_i;
        if (we_dcnt_i) d.dcnt = wdata_i[DCNT_W-1:0];
        if (we_ie_i)   d.ie   = wdata_i[IE_W-1:0];
        // write-one-to-clear, a same-cycle event wins
        if (we_is_i && wdata_i[B_DONE]) d.done = 1'b0;
        if (event_i) d.done = 1'b1;
        // channel reset sequence
        if (q.crst) begin
            if (q.cnt <= CNT_W'(1)) begin
                d.crst = 1'b0;
                d.cnt  = '0;
                d.on   = 1'b0;
                d.done = 1'b0;
            end else begin
                d.cnt = q.cnt - CNT_W'(1);
            end
        end
        if (glob_clr_i) d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        ctrl_o = '0;
        ctrl_o[B_ON]              = q.on;
        ctrl_o[B_CRST]            = q.crst;
        ctrl_o[B_TX]              = q.tx;
        ctrl_o[WGT_LO +: WGT_W]   = q.wgt;
        is_o         = '0;
        is_o[B_DONE] = q.done;
    end

    assign base_o      = q.base;
    assign dcnt_o      = DATA_W'(q.dcnt);
    assign ie_o        = DATA_W'(q.ie);
    assign on_o        = q.on;
    assign resetting_o = q.crst;
    assign done_o      = q.done;
    assign irq_o       = q.done & q.ie[B_DONE] & gie_i;
endmodule

// File: rtl/dma_port_bank.sv
module dma_port_bank
    import dma_regbank_pkg::*;
#(
    parameter int unsigned NUM_PORT = 5,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned SEL_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_sel_i,
    input  logic              we_ctrl_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] sel_o,
    output logic [DATA_W-1:0] ctrl_o
);
    localparam int unsigned PIDX_W = (NUM_PORT > 1) ? $clog2(NUM_PORT) : 1;

    typedef struct packed {
        logic [SEL_W-1:0]               ps;
        logic [NUM_PORT-1:0][PC_W-1:0]  pc;
    } port_t;

    port_t q, d;
    logic              sel_ok;
    logic [PIDX_W-1:0] pidx;
    wire unused_wdata = ^wdata_i;

    assign sel_ok = q.ps < SEL_W'(NUM_PORT);
    assign pidx   = q.ps[PIDX_W-1:0];

    always_comb begin
        d = q;
        if (we_sel_i) d.ps = wdata_i[SEL_W-1:0];
        if (we_ctrl_i && sel_ok) d.pc[pidx] = wdata_i[PC_HI:PC_LO];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        sel_o  = DATA_W'(q.ps);
        ctrl_o = '0;
        if (sel_ok) ctrl_o[PC_HI:PC_LO] = q.pc[pidx];
    end
endmodule

// File: rtl/dma_regbank.sv
module dma_regbank
    import dma_regbank_pkg::*;
#(
    parameter int unsigned NUM_CH     = 20,
    parameter int unsigned NUM_PORT   = 5,
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned SEL_W      = 8,
    parameter int unsigned DCNT_W     = 16,
    parameter int unsigned RST_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_CH-1:0] ch_event,
    output logic [NUM_CH-1:0] ch_on,
    output logic [NUM_CH-1:0] ch_irq,
    output logic              irq
);
    localparam int unsigned CIDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    typedef struct packed {
        logic [SEL_W-1:0]  cs;
        logic [NUM_CH-1:0] gie;
        logic              poll_en;
        logic              poll_div;
    } top_t;

    top_t q, d;
    wire unused_wdata = ^bus_wdata;

    logic hit_gctrl, hit_poll, hit_csel, hit_cctrl, hit_dbase, hit_dcnt;
    logic hit_cstat, hit_cien, hit_psel, hit_pctrl, hit_gmask;
    logic glob_clr, cs_ok;
    logic [CIDX_W-1:0] cidx;
    logic [SEL_W-1:0]  cs_q;
    logic [NUM_CH-1:0] gie_q, ch_rst_v, ch_done_v;
    logic [DATA_W-1:0] rd_ctrl [NUM_CH];
    logic [DATA_W-1:0] rd_base [NUM_CH];
    logic [DATA_W-1:0] rd_dcnt [NUM_CH];
    logic [DATA_W-1:0] rd_ie   [NUM_CH];
    logic [DATA_W-1:0] rd_is   [NUM_CH];
    logic [DATA_W-1:0] port_sel_rd, port_ctrl_rd;

    assign hit_gctrl = bus_we && (bus_addr == ADDR_W'(OFF_GCTRL));
    assign hit_poll  = bus_we && (bus_addr == ADDR_W'(OFF_POLL));
    assign hit_csel  = bus_we && (bus_addr == ADDR_W'(OFF_CSEL));
    assign hit_cctrl = bus_we && (bus_addr == ADDR_W'(OFF_CCTRL));
    assign hit_dbase = bus_we && (bus_addr == ADDR_W'(OFF_DBASE));
    assign hit_dcnt  = bus_we && (bus_addr == ADDR_W'(OFF_DCNT));
    assign hit_cstat = bus_we && (bus_addr == ADDR_W'(OFF_CSTAT));
    assign hit_cien  = bus_we && (bus_addr == ADDR_W'(OFF_CIEN));
    assign hit_psel  = bus_we && (bus_addr == ADDR_W'(OFF_PSEL));
    assign hit_pctrl = bus_we && (bus_addr == ADDR_W'(OFF_PCTRL));
    assign hit_gmask = bus_we && (bus_addr == ADDR_W'(OFF_GMASK));
    assign glob_clr  = hit_gctrl && bus_wdata[B_GRST];

    assign cs_q  = q.cs;
    assign gie_q = q.gie;
    assign cs_ok = q.cs < SEL_W'(NUM_CH);
    assign cidx  = q.cs[CIDX_W-1:0];

    always_comb begin
        d = q;
        if (hit_csel)  d.cs  = bus_wdata[SEL_W-1:0];
        if (hit_gmask) d.gie = bus_wdata[NUM_CH-1:0];
        if (hit_poll) begin
            d.poll_en  = bus_wdata[B_POLL_EN];
            d.poll_div = bus_wdata[B_POLL_DIV];
        end
        if (glob_clr) d.gie = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic mine;
        assign mine = (q.cs == SEL_W'(g));
        dma_chan_slot #(
            .DATA_W    (DATA_W),
            .DCNT_W    (DCNT_W),
            .IE_W      (8),
            .RST_CYCLES(RST_CYCLES)
        ) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .glob_clr_i (glob_clr),
            .we_ctrl_i  (hit_cctrl && mine),
            .we_base_i  (hit_dbase && mine),
            .we_dcnt_i  (hit_dcnt && mine),
            .we_ie_i    (hit_cien && mine),
            .we_is_i    (hit_cstat && mine),
            .wdata_i    (bus_wdata),
            .event_i    (ch_event[g]),
            .gie_i      (q.gie[g]),
            .ctrl_o     (rd_ctrl[g]),
            .base_o     (rd_base[g]),
            .dcnt_o     (rd_dcnt[g]),
            .ie_o       (rd_ie[g]),
            .is_o       (rd_is[g]),
            .on_o       (ch_on[g]),
            .resetting_o(ch_rst_v[g]),
            .done_o     (ch_done_v[g]),
            .irq_o      (ch_irq[g])
        );
    end

    dma_port_bank #(
        .NUM_PORT(NUM_PORT),
        .DATA_W  (DATA_W),
        .SEL_W   (SEL_W)
    ) u_ports (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_sel_i (hit_psel),
        .we_ctrl_i(hit_pctrl),
        .wdata_i  (bus_wdata),
        .sel_o    (port_sel_rd),
        .ctrl_o   (port_ctrl_rd)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFF_POLL): begin
                bus_rdata[B_POLL_EN]  = q.poll_en;
                bus_rdata[B_POLL_DIV] = q.poll_div;
            end
            ADDR_W'(OFF_CSEL):  bus_rdata = DATA_W'(q.cs);
            ADDR_W'(OFF_CCTRL): if (cs_ok) bus_rdata = rd_ctrl[cidx];
            ADDR_W'(OFF_DBASE): if (cs_ok) bus_rdata = rd_base[cidx];
            ADDR_W'(OFF_DCNT):  if (cs_ok) bus_rdata = rd_dcnt[cidx];
            ADDR_W'(OFF_CSTAT): if (cs_ok) bus_rdata = rd_is[cidx];
            ADDR_W'(OFF_CIEN):  if (cs_ok) bus_rdata = rd_ie[cidx];
            ADDR_W'(OFF_PSEL):  bus_rdata = port_sel_rd;
            ADDR_W'(OFF_PCTRL): bus_rdata = port_ctrl_rd;
            ADDR_W'(OFF_GMASK): bus_rdata = DATA_W'(q.gie);
            default:            bus_rdata = '0;
        endcase
    end

    assign irq = |ch_irq;
endmodule

// File: rtl/dma_regbank_chk.sv
module dma_regbank_chk
    import dma_regbank_pkg::*;
#(
    parameter int unsigned NUM_CH = 20,
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned SEL_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [NUM_CH-1:0] ch_event,
    input logic [NUM_CH-1:0] ch_on,
    input logic [NUM_CH-1:0] ch_irq,
    input logic              irq,
    input logic [NUM_CH-1:0] gie_q,
    input logic [SEL_W-1:0]  cs_q,
    input logic [NUM_CH-1:0] ch_rst_v,
    input logic [NUM_CH-1:0] ch_done_v,
    input logic              glob_clr
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_prop
        // R5: an event always leaves the flag set unless a reset clears it
        p_event_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
            ch_event[i] && !glob_clr && !ch_rst_v[i] |=> ch_done_v[i]);
        // R6: a masked channel never raises its line
        p_mask_gates_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !gie_q[i] |-> !ch_irq[i]);
        // R4: end of a reset leaves the channel off with no pending flag
        p_reset_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(ch_rst_v[i]) |-> !ch_on[i] && !ch_done_v[i]);
    end

    // R3: out-of-range selection cannot switch any channel
    p_oor_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we && (bus_addr == ADDR_W'(OFF_CCTRL)) && (cs_q >= SEL_W'(NUM_CH))
        && (ch_rst_v == '0) && !glob_clr |=> $stable(ch_on));

    // R9: engine reset clears every channel and the mask
    p_glob_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        glob_clr |=> (gie_q == '0) && (ch_on == '0) && (ch_done_v == '0));

    // R6: combined line is low when no channel line is high
    p_irq_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_irq == '0) |-> !irq);
endmodule

bind dma_regbank dma_regbank_chk #(
    .NUM_CH(NUM_CH),
    .ADDR_W(ADDR_W),
    .SEL_W (SEL_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .ch_event (ch_event),
    .ch_on    (ch_on),
    .ch_irq   (ch_irq),
    .irq      (irq),
    .gie_q    (gie_q),
    .cs_q     (cs_q),
    .ch_rst_v (ch_rst_v),
    .ch_done_v(ch_done_v),
    .glob_clr (glob_clr)
);

// File: tb/dma_regbank_tb.sv
`timescale 1ns/1ps
module dma_regbank_tb;
    localparam int NCH  = 20;
    localparam int RSTC = 4;

    localparam logic [11:0] A_GCTRL = 12'h010, A_POLL = 12'h014, A_CSEL = 12'h018,
                            A_CCTRL = 12'h01C, A_DBASE = 12'h020, A_DCNT = 12'h024,
                            A_CSTAT = 12'h028, A_CIEN = 12'h02C, A_PSEL = 12'h040,
                            A_PCTRL = 12'h044, A_GMASK = 12'h0F4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [11:0]     bus_addr = '0;
    logic            bus_we = 1'b0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NCH-1:0]  ch_event = '0;
    logic [NCH-1:0]  ch_on, ch_irq;
    logic            irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // model for the random phase
    bit          m_stat [NCH];
    bit          m_ie   [NCH];
    logic [NCH-1:0] m_gie;
    int          m_cs;

    always #2 clk = ~clk;

    dma_regbank u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ch_event(ch_event),
        .ch_on(ch_on), .ch_irq(ch_irq), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_we = 1'b1;
        @(posedge clk);
        #1 bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        #1 v = bus_rdata;
    endtask

    task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic pulse(input int ch);
        @(negedge clk);
        ch_event[ch] = 1'b1;
        @(posedge clk);
        #1 ch_event = '0;
    endtask

    function automatic logic [NCH-1:0] exp_irq();
        logic [NCH-1:0] r;
        for (int i = 0; i < NCH; i++) r[i] = m_stat[i] & m_ie[i] & m_gie[i];
        return r;
    endfunction

    function automatic logic [31:0] exp_stat_rd();
        if (m_cs >= NCH) return 32'h0;
        return m_stat[m_cs] ? 32'h8 : 32'h0;
    endfunction

    // one random-phase cycle: drive, update model at the edge, check
    task automatic step(input logic [NCH-1:0] ev, input bit we, input logic [11:0] a,
                        input logic [31:0] v);
        bit ns [NCH];
        @(negedge clk);
        ch_event = ev; bus_we = we; bus_addr = a; bus_wdata = v;
        for (int i = 0; i < NCH; i++) begin
            bit clr;
            clr = we && (a == A_CSTAT) && (m_cs == i) && v[3];
            ns[i] = (m_stat[i] && !clr) || ev[i];
        end
        @(posedge clk);
        for (int i = 0; i < NCH; i++) begin
            m_stat[i] = ns[i];
            if (we && (a == A_CIEN) && (m_cs == i)) m_ie[i] = v[3];
        end
        if (we && a == A_GMASK) m_gie = v[NCH-1:0];
        if (we && a == A_CSEL)  m_cs = int'(v[7:0]);
        #1;
        bus_we = 1'b0; ch_event = '0;
        chk("R6 random ch_irq", 32'(ch_irq), 32'(exp_irq()));
        chk("R6 random irq", 32'(irq), 32'(|exp_irq()));
        if (!we && a == A_CSTAT) chk("R5/R3 random status readback", bus_rdata, exp_stat_rd());
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int cnt;
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        #1;
        chk("R1 ch_on", 32'(ch_on), 32'h0);
        chk("R1 ch_irq", 32'(ch_irq), 32'h0);
        chk("R1 irq", 32'(irq), 32'h0);
        rd_chk("R1 chan select", A_CSEL, 32'h0);
        rd_chk("R1 global mask", A_GMASK, 32'h0);
        rd_chk("R1 poll control", A_POLL, 32'h0);
        rd_chk("R1 chan control", A_CCTRL, 32'h0);

        // R2 banked access and field masks
        wr(A_CSEL, 32'd5);
        wr(A_CCTRL, 32'hFFFF_FFFD);
        rd_chk("R2 control fields", A_CCTRL, 32'h0003_0101);
        #1 chk("R2 ch_on output", 32'(ch_on), 32'(1) << 5);
        wr(A_DBASE, 32'hDEAD_BEE4);
        rd_chk("R2 descriptor base", A_DBASE, 32'hDEAD_BEE4);
        wr(A_DCNT, 32'h1234_0040);
        rd_chk("R2 descriptor count", A_DCNT, 32'h0000_0040);
        wr(A_CIEN, 32'h0000_0FFF);
        rd_chk("R2 interrupt enable", A_CIEN, 32'h0000_00FF);
        wr(A_CSEL, 32'd7);
        rd_chk("R2 other bank control", A_CCTRL, 32'h0);
        rd_chk("R2 other bank base", A_DBASE, 32'h0);

        // R3 out-of-range channel select
        wr(A_CSEL, 32'd20);
        wr(A_CCTRL, 32'h0000_0001);
        wr(A_DBASE, 32'h0000_0055);
        rd_chk("R3 oor control reads 0", A_CCTRL, 32'h0);
        rd_chk("R3 oor base reads 0", A_DBASE, 32'h0);
        wr(A_CSEL, 32'd19);
        rd_chk("R3 last channel untouched", A_CCTRL, 32'h0);
        rd_chk("R3 last channel base untouched", A_DBASE, 32'h0);
        #1 chk("R3 ch_on unchanged", 32'(ch_on), 32'(1) << 5);

        // R5 status set / write-one-to-clear / collision
        wr(A_CSEL, 32'd5);
        wr(A_CIEN, 32'h0);
        pulse(5);
        rd_chk("R5 event sets bit 3", A_CSTAT, 32'h8);
        wr(A_CSTAT, 32'h77);
        rd_chk("R5 zero in bit 3 keeps flag", A_CSTAT, 32'h8);
        wr(A_CSTAT, 32'h7E);
        rd_chk("R5 ack clears flag", A_CSTAT, 32'h0);
        pulse(5);
        @(negedge clk);
        bus_addr = A_CSTAT; bus_wdata = 32'h7E; bus_we = 1'b1; ch_event[5] = 1'b1;
        @(posedge clk);
        #1 bus_we = 1'b0; ch_event = '0;
        rd_chk("R5 event beats same-cycle clear", A_CSTAT, 32'h8);

        // R6 interrupt gating
        wr(A_CIEN, 32'h8);
        #1 chk("R6 masked by global", 32'(ch_irq), 32'h0);
        wr(A_GMASK, 32'hFFFF_FFFF);
        rd_chk("R6 mask width", A_GMASK, 32'h000F_FFFF);
        #1 chk("R6 line raised", 32'(ch_irq), 32'(1) << 5);
        chk("R6 combined raised", 32'(irq), 32'h1);
        wr(A_CIEN, 32'h0);
        #1 chk("R6 enable off", 32'(ch_irq), 32'h0);
        chk("R6 combined low", 32'(irq), 32'h0);

        // R4 channel reset sequence
        wr(A_CCTRL, 32'h0003_0103);
        cnt = 0;
        for (int k = 0; k < 100; k++) begin
            rd(A_CCTRL, v);
            if (!v[1]) break;
            cnt++;
        end
        chk("R4 reset bit busy cycles", 32'(cnt), 32'(RSTC));
        rd_chk("R4 control after reset", A_CCTRL, 32'h0003_0100);
        rd_chk("R4 status cleared", A_CSTAT, 32'h0);
        #1 chk("R4 ch_on cleared", 32'(ch_on), 32'h0);

        // R7 port control
        wr(A_PSEL, 32'd1);
        wr(A_PCTRL, 32'hFFFF_FFFF);
        rd_chk("R7 port field mask", A_PCTRL, 32'h0000_0FFC);
        wr(A_PSEL, 32'd0);
        rd_chk("R7 other port", A_PCTRL, 32'h0);
        wr(A_PSEL, 32'd5);
        wr(A_PCTRL, 32'h0000_0F40);
        rd_chk("R7 oor port reads 0", A_PCTRL, 32'h0);
        rd_chk("R7 port select readback", A_PSEL, 32'd5);
        wr(A_PSEL, 32'd1);
        rd_chk("R7 port kept", A_PCTRL, 32'h0000_0FFC);

        // R8 polling control
        wr(A_POLL, 32'hFFFF_FFFF);
        rd_chk("R8 poll bits", A_POLL, 32'h8000_0040);
        wr(A_POLL, 32'h0000_0040);
        rd_chk("R8 div only", A_POLL, 32'h0000_0040);

        // R10 unmapped
        wr(12'h030, 32'hFFFF_FFFF);
        rd_chk("R10 unmapped reads 0", 12'h030, 32'h0);
        rd_chk("R10 poll untouched", A_POLL, 32'h0000_0040);

        // R9 engine reset
        wr(A_CCTRL, 32'h1);
        wr(A_CIEN, 32'h8);
        pulse(5);
        #1 chk("R9 setup irq", 32'(irq), 32'h1);
        wr(A_GCTRL, 32'h1);
        #1 chk("R9 ch_on cleared", 32'(ch_on), 32'h0);
        chk("R9 irq cleared", 32'(irq), 32'h0);
        rd_chk("R9 mask cleared", A_GMASK, 32'h0);
        rd_chk("R9 control cleared", A_CCTRL, 32'h0);
        rd_chk("R9 status cleared", A_CSTAT, 32'h0);
        rd_chk("R9 enable cleared", A_CIEN, 32'h0);
        rd_chk("R9 reads 0", A_GCTRL, 32'h0);

        // random phase, model starts from the cleared state, select = 5
        for (int i = 0; i < NCH; i++) begin m_stat[i] = 0; m_ie[i] = 0; end
        m_gie = '0; m_cs = 5;
        for (int n = 0; n < 600; n++) begin
            logic [NCH-1:0] ev;
            int op;
            ev = NCH'($urandom & $urandom & $urandom);
            op = int'($urandom % 8);
            case (op)
                0: step(ev, 1'b1, A_CSEL, 32'($urandom % 24));
                1: step(ev, 1'b1, A_CIEN, $urandom);
                2: step(ev, 1'b1, A_CSTAT, $urandom);
                3: step(ev, 1'b1, A_GMASK, $urandom);
                4: step(ev, 1'b1, A_CSTAT, 32'h7E);
                default: step(ev, 1'b0, A_CSTAT, 32'h0);
            endcase
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule